// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Calculator

This block turns a video pixel clock, given in kHz, into the numerator/denominator pairs (N and CTS) that a display link transmitter sends so that a sink can rebuild the audio sample clock. It produces one pair for each of three audio sample rates: 32 kHz, 44.1 kHz and 48 kHz. A request is made by pulsing `start` with the pixel clock on `pix_clk_khz`. The block raises `busy`, works out all six values, and then pulses `done`. The results stay on the outputs until the next accepted request.

Ten common video clocks are answered from a built-in preset list. Any other clock goes through an arithmetic path. That path starts from the fraction (128·fs) / (clock·1000) and reduces it with an iterative Euclid loop that takes one remainder step per cycle. It then scales the reduced pair up by the smallest whole factor that brings N to or above the ideal value floor(128·fs/1000). Each rate also carries two warning flags. They mark an N that falls outside the range accepted by sinks, and the values are delivered even when a flag is set.

Top module: `acr_calc`

## Requirements
- R1: After reset `busy` and `done` are low, and all six value outputs and both warning vectors are zero.
- R2: A `start` seen while `busy` is low is accepted, and `busy` is high in the following cycle. A `start` seen while `busy` is high is ignored and does not change the results of the request in progress.
- R3: Each request ends with `done` high for exactly one cycle. `busy` is low in that cycle and was high in the cycle before.
- R4: While `busy` is low, the value outputs and warning flags do not change, whatever `pix_clk_khz` does.
- R5: Preset clocks (25175, 25200, 27000, 27027, 54000, 54054, 74176, 74250, 148352, 148500 kHz) return N=4096 with CTS=clock for 32 kHz, and N=6144 with CTS=clock for 48 kHz. For 44.1 kHz they return these N/CTS pairs: 28224/125875 for 25175; 6272/28000 for 25200; 6272/30000 for 27000; 6272/30030 for 27027; 6272/60000 for 54000; 6272/60060 for 54054; 5733/75335 for 74176; 6272/82500 for 74250; 5733/150670 for 148352; 6272/165000 for 148500. All warning flags are clear.
- R6: For any other clock, the pair is first reduced: N0 = 128·fs and C0 = clock·1000, each divided by gcd(N0, C0). A clock of 0 gives gcd = N0.
- R7: The reduced pair is then multiplied by m = ceil(floor(128·fs/1000) / N_reduced). This gives the smallest multiple of the reduced N that is not below floor(128·fs/1000).
- R8: warn_low[r] is set when N < floor(128·fs/1500), and warn_high[r] is set when N > floor(128·fs/300). The computed N and CTS are still output.
- R9: Each N and CTS output carries the low OUT_W (default 20) bits of its value, computed with 32-bit arithmetic.
- R10: A `start` in the same cycle as `done` is accepted as a new request.
- R11: Bit positions in `warn_low`/`warn_high`: bit 0 is 32 kHz, bit 1 is 44.1 kHz and bit 2 is 48 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| pix_clk_khz | input | CLK_W (18) | Pixel clock in kHz |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| n_32k | output | OUT_W (20) | N for 32 kHz |
| cts_32k | output | OUT_W (20) | CTS for 32 kHz |
| n_44k | output | OUT_W (20) | N for 44.1 kHz |
| cts_44k | output | OUT_W (20) | CTS for 44.1 kHz |
| n_48k | output | OUT_W (20) | N for 48 kHz |
| cts_48k | output | OUT_W (20) | CTS for 48 kHz |
| warn_low | output | 3 | N below the allowed range, one bit per rate |
| warn_high | output | 3 | N above the allowed range, one bit per rate |

## Verification
Two things can happen in the same cycle: the completion pulse of one request and the acceptance of the next `start`. The bench provokes this by raising `start` with a new pixel clock in exactly the cycle in which it sees `done`. It then requires `busy` to be high one cycle later, and requires the next completion to carry the new clock's values and not a stale set. The bench also presents a `start` in the middle of a miss-path calculation. The results must then still match the first clock, which shows that a request in flight is not restarted by a second one.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int unsigned NUM_RATES = 3;
    localparam int unsigned CALC_W    = 32;

    typedef logic [CALC_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SEED,
        ST_REDUCE,
        ST_FINISH
    } phase_t;

    typedef struct packed {
        word_t n;
        word_t cts;
    } acr_pair_t;

    typedef acr_pair_t [NUM_RATES-1:0] pair_vec_t;

    typedef struct packed {
        logic      hit;
        pair_vec_t pairs;
    } preset_t;

    // Sample rate in Hz for rate slot 0/1/2
    function automatic word_t rate_hz(input logic [1:0] idx);
        case (idx)
            2'd0:    return word_t'(32000);
            2'd1:    return word_t'(44100);
            default: return word_t'(48000);
        endcase
    endfunction

    function automatic word_t ideal_n(input logic [1:0] idx);
        return (word_t'(128) * rate_hz(idx)) / word_t'(1000);
    endfunction

    function automatic word_t low_limit(input logic [1:0] idx);
        return (word_t'(128) * rate_hz(idx)) / word_t'(1500);
    endfunction

    function automatic word_t high_limit(input logic [1:0] idx);
        return (word_t'(128) * rate_hz(idx)) / word_t'(300);
    endfunction

    // Preset answers for common video clocks
    function automatic preset_t preset_lookup(input word_t clk_khz);
        preset_t r;
        word_t   n_mid;
        word_t   c_mid;
        r     = '0;
        r.hit = 1'b1;
        case (clk_khz)
            word_t'(25175):  begin n_mid = word_t'(28224); c_mid = word_t'(125875); end
            word_t'(25200):  begin n_mid = word_t'(6272);  c_mid = word_t'(28000);  end
            word_t'(27000):  begin n_mid = word_t'(6272);  c_mid = word_t'(30000);  end
            word_t'(27027):  begin n_mid = word_t'(6272);  c_mid = word_t'(30030);  end
            word_t'(54000):  begin n_mid = word_t'(6272);  c_mid = word_t'(60000);  end
            word_t'(54054):  begin n_mid = word_t'(6272);  c_mid = word_t'(60060);  end
            word_t'(74176):  begin n_mid = word_t'(5733);  c_mid = word_t'(75335);  end
            word_t'(74250):  begin n_mid = word_t'(6272);  c_mid = word_t'(82500);  end
            word_t'(148352): begin n_mid = word_t'(5733);  c_mid = word_t'(150670); end
            word_t'(148500): begin n_mid = word_t'(6272);  c_mid = word_t'(165000); end
            default:         begin n_mid = '0; c_mid = '0; r.hit = 1'b0; end
        endcase
        if (r.hit) begin
            r.pairs[0].n   = word_t'(4096);
            r.pairs[0].cts = clk_khz;
            r.pairs[1].n   = n_mid;
            r.pairs[1].cts = c_mid;
            r.pairs[2].n   = word_t'(6144);
            r.pairs[2].cts = clk_khz;
        end
        return r;
    endfunction

endpackage

// File: rtl/acr_preset_rom.sv
module acr_preset_rom
    import acr_pkg::*;
(
    input  word_t     clk_khz,
    output logic      hit,
    output pair_vec_t pairs
);
    preset_t found;

    always_comb begin
        found = preset_lookup(clk_khz);
        hit   = found.hit;
        pairs = found.pairs;
    end
endmodule

// File: rtl/acr_euclid.sv
module acr_euclid #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] gcd,
    output logic         settled
);
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= a_in;
            b_q <= b_in;
        end else if (b_q != '0) begin
            a_q <= b_q;
            b_q <= a_q % b_q;
        end
    end

    assign gcd     = a_q;
    assign settled = (b_q == '0);
endmodule

// File: rtl/acr_rescale.sv
module acr_rescale
    import acr_pkg::*;
(
    input  word_t n_seed,
    input  word_t c_seed,
    input  word_t gcd,
    input  word_t ideal,
    input  word_t lo_lim,
    input  word_t hi_lim,
    output word_t n_out,
    output word_t c_out,
    output logic  warn_lo,
    output logic  warn_hi
);
    word_t n_red;
    word_t c_red;
    word_t mul;

    always_comb begin
        if (gcd != '0) begin
            n_red = n_seed / gcd;
            c_red = c_seed / gcd;
        end else begin
            n_red = n_seed;
            c_red = c_seed;
        end
        if (n_red != '0) mul = (ideal + n_red - word_t'(1)) / n_red;
        else             mul = word_t'(1);
        n_out   = n_red * mul;
        c_out   = c_red * mul;
        warn_lo = (n_out < lo_lim);
        warn_hi = (n_out > hi_lim);
    end
endmodule

// File: rtl/acr_calc.sv
module acr_calc
    import acr_pkg::*;
#(
    parameter int unsigned CLK_W = 18,
    parameter int unsigned OUT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CLK_W-1:0] pix_clk_khz,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] n_32k,
    output logic [OUT_W-1:0] cts_32k,
    output logic [OUT_W-1:0] n_44k,
    output logic [OUT_W-1:0] cts_44k,
    output logic [OUT_W-1:0] n_48k,
    output logic [OUT_W-1:0] cts_48k,
    output logic [2:0]       warn_low,
    output logic [2:0]       warn_high
);
    localparam int unsigned PAD_W   = CALC_W - CLK_W;
    localparam logic [1:0]  LAST_IX = 2'(NUM_RATES - 1);

    phase_t     phase;
    word_t      clk_q;
    logic [1:0] idx;
    pair_vec_t  res;
    logic [NUM_RATES-1:0] lo_q;
    logic [NUM_RATES-1:0] hi_q;
    logic       done_q;

    logic       rom_hit;
    pair_vec_t  rom_pairs;
    word_t      n_seed;
    word_t      c_seed;
    word_t      eu_gcd;
    logic       eu_settled;
    word_t      sc_n;
    word_t      sc_c;
    logic       sc_lo;
    logic       sc_hi;

    assign n_seed = word_t'(128) * rate_hz(idx);
    assign c_seed = clk_q * word_t'(1000);

    acr_preset_rom rom_i (
        .clk_khz (clk_q),
        .hit     (rom_hit),
        .pairs   (rom_pairs)
    );

    acr_euclid #(.W(CALC_W)) euclid_i (
        .clk     (clk),
        .rst     (rst),
        .load    (phase == ST_SEED),
        .a_in    (n_seed),
        .b_in    (c_seed),
        .gcd     (eu_gcd),
        .settled (eu_settled)
    );

    acr_rescale scale_i (
        .n_seed  (n_seed),
        .c_seed  (c_seed),
        .gcd     (eu_gcd),
        .ideal   (ideal_n(idx)),
        .lo_lim  (low_limit(idx)),
        .hi_lim  (high_limit(idx)),
        .n_out   (sc_n),
        .c_out   (sc_c),
        .warn_lo (sc_lo),
        .warn_hi (sc_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= ST_IDLE;
            clk_q  <= '0;
            idx    <= '0;
            res    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        clk_q <= {{PAD_W{1'b0}}, pix_clk_khz};
                        phase <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    idx <= '0;
                    if (rom_hit) begin
                        res   <= rom_pairs;
                        lo_q  <= '0;
                        hi_q  <= '0;
                        phase <= ST_FINISH;
                    end else begin
                        phase <= ST_SEED;
                    end
                end
                ST_SEED: phase <= ST_REDUCE;
                ST_REDUCE: begin
                    if (eu_settled) begin
                        res[idx].n   <= sc_n;
                        res[idx].cts <= sc_c;
                        lo_q[idx]    <= sc_lo;
                        hi_q[idx]    <= sc_hi;
                        if (idx == LAST_IX) begin
                            phase <= ST_FINISH;
                        end else begin
                            idx   <= idx + 2'd1;
                            phase <= ST_SEED;
                        end
                    end
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                    phase  <= ST_IDLE;
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    logic [OUT_W-1:0] n_vec [NUM_RATES];
    logic [OUT_W-1:0] c_vec [NUM_RATES];

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_out
        assign n_vec[r] = res[r].n[OUT_W-1:0];
        assign c_vec[r] = res[r].cts[OUT_W-1:0];
    end

    assign n_32k     = n_vec[0];
    assign cts_32k   = c_vec[0];
    assign n_44k     = n_vec[1];
    assign cts_44k   = c_vec[1];
    assign n_48k     = n_vec[2];
    assign cts_48k   = c_vec[2];
    assign warn_low  = lo_q;
    assign warn_high = hi_q;
    assign busy      = (phase != ST_IDLE);
    assign done      = done_q;
endmodule

// File: rtl/acr_calc_chk.sv
module acr_calc_chk #(
    parameter int unsigned OUT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] n_32k,
    input logic [OUT_W-1:0] cts_32k,
    input logic [OUT_W-1:0] n_44k,
    input logic [OUT_W-1:0] cts_44k,
    input logic [OUT_W-1:0] n_48k,
    input logic [OUT_W-1:0] cts_48k,
    input logic [2:0]       warn_low,
    input logic [2:0]       warn_high
);
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(n_32k) && $stable(cts_32k) && $stable(n_44k) &&
                   $stable(cts_44k) && $stable(n_48k) && $stable(cts_48k) &&
                   $stable(warn_low) && $stable(warn_high))); // R4
endmodule

bind acr_calc acr_calc_chk #(.OUT_W(OUT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .n_32k     (n_32k),
    .cts_32k   (cts_32k),
    .n_44k     (n_44k),
    .cts_44k   (cts_44k),
    .n_48k     (n_48k),
    .cts_48k   (cts_48k),
    .warn_low  (warn_low),
    .warn_high (warn_high)
);

// File: tb/acr_calc_tb_top.sv
module acr_calc_tb_top;
    localparam int unsigned CLK_W = 18;
    localparam int unsigned OUT_W = 20;
    localparam longint      MASK  = (64'd1 << OUT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CLK_W-1:0] pix = '0;
    logic             busy, done;
    logic [OUT_W-1:0] n_32k, cts_32k, n_44k, cts_44k, n_48k, cts_48k;
    logic [2:0]       warn_low, warn_high;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    longint   exp_n [3];
    longint   exp_c [3];
    logic [2:0] exp_lo, exp_hi;

    always #2 clk = ~clk;

    acr_calc #(.CLK_W(CLK_W), .OUT_W(OUT_W)) dut_i (
        .clk (clk), .rst (rst), .start (start), .pix_clk_khz (pix),
        .busy (busy), .done (done),
        .n_32k (n_32k), .cts_32k (cts_32k), .n_44k (n_44k), .cts_44k (cts_44k),
        .n_48k (n_48k), .cts_48k (cts_48k),
        .warn_low (warn_low), .warn_high (warn_high)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic longint fs_of(input int r);
        return (r == 0) ? 64'd32000 : (r == 1) ? 64'd44100 : 64'd48000;
    endfunction

    // Expected values from the requirements (R5..R9)
    task automatic compute_expect(input longint ck);
        longint n44, c44;
        bit hit = 1'b1;
        case (ck)
            25175:  begin n44 = 28224; c44 = 125875; end
            25200:  begin n44 = 6272;  c44 = 28000;  end
            27000:  begin n44 = 6272;  c44 = 30000;  end
            27027:  begin n44 = 6272;  c44 = 30030;  end
            54000:  begin n44 = 6272;  c44 = 60000;  end
            54054:  begin n44 = 6272;  c44 = 60060;  end
            74176:  begin n44 = 5733;  c44 = 75335;  end
            74250:  begin n44 = 6272;  c44 = 82500;  end
            148352: begin n44 = 5733;  c44 = 150670; end
            148500: begin n44 = 6272;  c44 = 165000; end
            default: begin hit = 1'b0; n44 = 0; c44 = 0; end
        endcase
        exp_lo = '0;
        exp_hi = '0;
        if (hit) begin
            exp_n[0] = 4096; exp_c[0] = ck;
            exp_n[1] = n44;  exp_c[1] = c44;
            exp_n[2] = 6144; exp_c[2] = ck;
        end else begin
            for (int r = 0; r < 3; r++) begin
                longint a = 128 * fs_of(r);
                longint b = ck * 1000;
                longint t, g, nr, cr, ideal, m, nn, cc;
                longint x = a;
                longint y = b;
                while (y != 0) begin
                    t = x % y;
                    x = y;
                    y = t;
                end
                g = x;
                nr = a / g;
                cr = b / g;
                ideal = (128 * fs_of(r)) / 1000;
                m = (ideal + nr - 1) / nr;
                nn = (nr * m) & 64'hFFFF_FFFF;
                cc = (cr * m) & 64'hFFFF_FFFF;
                exp_n[r] = nn;
                exp_c[r] = cc;
                exp_lo[r] = (nn < (128 * fs_of(r)) / 1500);
                exp_hi[r] = (nn > (128 * fs_of(r)) / 300);
            end
        end
    endtask

    function automatic longint act_n(input int r);
        return (r == 0) ? longint'(n_32k) : (r == 1) ? longint'(n_44k) : longint'(n_48k);
    endfunction

    function automatic longint act_c(input int r);
        return (r == 0) ? longint'(cts_32k) : (r == 1) ? longint'(cts_44k) : longint'(cts_48k);
    endfunction

    task automatic compare_all(input string req);
        for (int r = 0; r < 3; r++) begin
            chk(act_n(r) == (exp_n[r] & MASK), req, $sformatf("N rate%0d", r),
                act_n(r), exp_n[r] & MASK);
            chk(act_c(r) == (exp_c[r] & MASK), req, $sformatf("CTS rate%0d", r),
                act_c(r), exp_c[r] & MASK);
        end
        chk(warn_low == exp_lo, req, "warn_low", longint'(warn_low), longint'(exp_lo));
        chk(warn_high == exp_hi, req, "warn_high", longint'(warn_high), longint'(exp_hi));
    endtask

    task automatic launch(input longint ck);
        pix   = CLK_W'(ck);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, "done seen", longint'(done), 1);
    endtask

    task automatic run_one(input longint ck, input string req);
        launch(ck);
        wait_done(req);
        compute_expect(ck);
        compare_all(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        longint tbl [10] = '{25175, 25200, 27000, 27027, 54000, 54054,
                             74176, 74250, 148352, 148500};
        seed_dummy = $urandom(32'd4242);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", longint'(busy), 0);
        chk(done == 1'b0, "R1", "done", longint'(done), 0);
        chk(n_32k == '0 && cts_48k == '0 && n_44k == '0, "R1", "outputs", longint'(n_32k), 0);
        chk(warn_low == '0 && warn_high == '0, "R1", "flags",
            longint'({warn_low, warn_high}), 0);

        // R2 busy follows accepted start; R5 preset hit
        launch(74250);
        chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        wait_done("R5");
        chk(busy == 1'b0, "R3", "busy at done", longint'(busy), 0);
        compute_expect(74250);
        compare_all("R5");
        @(negedge clk);
        chk(done == 1'b0, "R3", "done one cycle", longint'(done), 0);

        // R5 all preset clocks
        foreach (tbl[i]) run_one(tbl[i], "R5");

        // R6 R7 miss path, directed
        run_one(100000, "R6_R7");
        run_one(0, "R6");
        // R8 R11 high warning on 44.1 kHz slot (bit 1)
        run_one(1, "R8_R11");
        chk(warn_high == 3'b010, "R11", "warn_high bit", longint'(warn_high), 2);
        // R9 truncation of CTS above 20 bits
        run_one(209717, "R9");

        // R2 start during busy ignored
        launch(100000);
        @(negedge clk);
        pix = CLK_W'(27000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R2");
        compute_expect(100000);
        compare_all("R2");

        // R4 hold while idle with changing input
        pix = CLK_W'(12345);
        repeat (10) @(negedge clk);
        compare_all("R4");

        // R10 start in the done cycle
        launch(54000);
        wait_done("R10");
        pix   = CLK_W'(123457);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after done-cycle start", longint'(busy), 1);
        wait_done("R10");
        compute_expect(123457);
        compare_all("R10");

        // Random clocks, fixed seed
        for (int k = 0; k < 40; k++) begin
            longint ck = longint'($urandom % 200001);
            run_one(ck, "R6_R7_R8");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule